// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital sequencer of a 12-bit charge-redistribution successive approximation converter. It splits time into frames of fifteen numbered clock periods. The first three periods are the track window, in which the capacitor array follows the input and the comparator settles. The other twelve periods are bit trials, tested from the most significant bit down. The block drives the track control and the trial code to the array and reads back a single comparator bit. It moves the finished code into a holding register and raises a data-ready flag for one period.

A low start input makes frames run back to back. When start is high at the period-1 decision, the sequencer parks in track with data-ready held. A later low start restarts it at the last track period. The held result leaves on a 12-bit bus with separate active-low enables for its upper eight and lower four bits. A disabled part floats.

Top module: `sar_conv_seq`

## Requirements
- R1: With start held low, frames run back to back and each frame lasts exactly 15 clock periods, so data-ready rises every 15 cycles.
- R2: Track is high in periods 1 to 3 only, and the trial code is all zeros while track is high.
- R3: In period 4 the trial code is 0x800: bit 11 set and all other bits clear.
- R4: Bits 11 down to 1 are decided at the ends of periods 4 to 14 and bit 0 at the end of period 15. A decided bit keeps the comparator value, and the next lower bit is set for its own trial, so the period-5 trial is (bit 11 result) | 0x400.
- R5: The result is straight binary, with the MSB on bus bit 11. It is loaded at the end of period 15 and is visible from period 1 of the next frame. With the comparator high whenever the input code is at or above the trial code, codes 0 through 4095 come back unchanged.
- R6: In free-running operation data-ready is high in period 1 only and is low from period 2 on.
- R7: If start is high at the end of period 1, the sequencer stays in period 1. Track stays high, the trial code stays zero and data-ready keeps its value.
- R8: Start passes through a two-flop synchronizer. From a parked state, the third rising edge after start goes low clears data-ready and moves to period 3. Data-ready rises again 13 cycles later, when the new result is shown.
- R9: The result register changes only at the edge where data-ready rises and holds through the whole following frame.
- R10: oe_hi_n low drives bits 11 to 4 and oe_lo_n low drives bits 3 to 0. Each part floats (high impedance) while its enable is high, independently of the other part.
- R11: A synchronous active-high reset gives period 1 with track high, data-ready low, trial code zero and result zero. It also marks start as inactive in the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all actions on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low start (low = continuous, high = park after a frame) |
| cmp_i | input | 1 | Comparator result for the current trial code |
| oe_hi_n | input | 1 | Active-low enable for result bits 11 to 4 |
| oe_lo_n | input | 1 | Active-low enable for result bits 3 to 0 |
| track_o | output | 1 | Array tracks the input and comparator auto-balances |
| trial_o | output | 12 | Trial code driven to the capacitor array |
| ready_o | output | 1 | Data-ready flag |
| data_o | output | 12 | Held result, per-part high impedance |

## Verification
The bench models the comparator as a compare of the trial code against a stored input code. It converts codes 0, 4095, 0x800, 0x7FF, 0xA5A and 1. All-zero and all-one codes show whether each decision keeps or clears its bit. The two codes on either side of mid-scale separate a wrong MSB decision from an off-by-one in the bit order. The patterned code catches swapped or shifted bits. Free-running frames are timed period by period, and a parked single-shot frame measures the synchronizer latency and the 13-cycle restart path. With a pulled-up bus, each enable is set on its own to show that it controls only its own part.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    localparam int DEF_NBITS   = 12;
    localparam int DEF_TRACK   = 3;
    localparam int DEF_LO_BITS = 4;

    function automatic int frame_len(input int nbits, input int trk);
        return nbits + trk;
    endfunction

    function automatic int per_width(input int nbits, input int trk);
        return $clog2(nbits + trk + 1);
    endfunction
endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS   = DEF_NBITS,
    parameter int TRACK_P = DEF_TRACK,
    localparam int NPER   = frame_len(NBITS, TRACK_P),
    localparam int PW     = per_width(NBITS, TRACK_P)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_n,
    output logic [PW-1:0] per_o,
    output logic          track_o,
    output logic          ready_o,
    output logic          last_o
);
    localparam logic [PW-1:0] P_FIRST  = PW'(1);
    localparam logic [PW-1:0] P_SECOND = PW'(2);
    localparam logic [PW-1:0] P_TRK    = PW'(TRACK_P);
    localparam logic [PW-1:0] P_LAST   = PW'(NPER);

    typedef struct packed {
        logic [1:0]    sync;
        logic [PW-1:0] per;
        logic          parked;
        logic          ready;
    } phase_t;

    phase_t st_d, st_q;
    logic   go;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], start_n};
        go        = ~st_q.sync[1];
        if (st_q.per == P_FIRST) begin
            if (go) begin
                st_d.per    = st_q.parked ? P_TRK : P_SECOND;
                st_d.parked = 1'b0;
                st_d.ready  = 1'b0;
            end else begin
                st_d.parked = 1'b1;
            end
        end else if (st_q.per == P_LAST) begin
            st_d.per   = P_FIRST;
            st_d.ready = 1'b1;
        end else begin
            st_d.per = st_q.per + P_FIRST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sync   <= 2'b11;
            st_q.per    <= P_FIRST;
            st_q.parked <= 1'b0;
            st_q.ready  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign per_o   = st_q.per;
    assign track_o = (st_q.per <= P_TRK);
    assign ready_o = st_q.ready;
    assign last_o  = (st_q.per == P_LAST);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int NBITS   = DEF_NBITS,
    parameter int TRACK_P = DEF_TRACK,
    localparam int NPER   = frame_len(NBITS, TRACK_P),
    localparam int PW     = per_width(NBITS, TRACK_P)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    per_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] trial_o,
    output logic [NBITS-1:0] final_o
);
    localparam logic [PW-1:0]    P_TRK    = PW'(TRACK_P);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    typedef struct packed {
        logic [NBITS-1:0] code;
    } trial_t;

    trial_t tr_d, tr_q;
    int     bidx;

    always_comb begin
        tr_d = tr_q;
        bidx = NPER - int'(per_i);
        if (per_i == P_TRK) begin
            tr_d.code = MSB_ONLY;
        end else if (per_i > P_TRK) begin
            for (int i = 0; i < NBITS; i++) begin
                if (i == bidx)     tr_d.code[i] = cmp_i;
                if (i + 1 == bidx) tr_d.code[i] = 1'b1;
            end
            if (bidx == 0) tr_d.code = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tr_q.code <= '0;
        else     tr_q      <= tr_d;
    end

    assign trial_o = tr_q.code;
    assign final_o = {tr_q.code[NBITS-1:1], cmp_i};
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg
    import sar_seq_pkg::*;
#(
    parameter int NBITS = DEF_NBITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [NBITS-1:0] code_i,
    output logic [NBITS-1:0] res_o
);
    typedef struct packed {
        logic [NBITS-1:0] res;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load_i) h_d.res = code_i;
    end

    always_ff @(posedge clk) begin
        if (rst) h_q.res <= '0;
        else     h_q     <= h_d;
    end

    assign res_o = h_q.res;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS   = DEF_NBITS,
    parameter int TRACK_P = DEF_TRACK,
    parameter int LO_BITS = DEF_LO_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             cmp_i,
    input  logic             oe_hi_n,
    input  logic             oe_lo_n,
    output logic             track_o,
    output logic [NBITS-1:0] trial_o,
    output logic             ready_o,
    output logic [NBITS-1:0] data_o
);
    localparam int PW = per_width(NBITS, TRACK_P);

    logic [PW-1:0]    per;
    logic             last;
    logic [NBITS-1:0] final_code;
    logic [NBITS-1:0] res_code;

    sar_phase_ctrl #(.NBITS(NBITS), .TRACK_P(TRACK_P)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .per_o   (per),
        .track_o (track_o),
        .ready_o (ready_o),
        .last_o  (last)
    );

    sar_trial_reg #(.NBITS(NBITS), .TRACK_P(TRACK_P)) u_trial (
        .clk     (clk),
        .rst     (rst),
        .per_i   (per),
        .cmp_i   (cmp_i),
        .trial_o (trial_o),
        .final_o (final_code)
    );

    sar_result_reg #(.NBITS(NBITS)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (last),
        .code_i (final_code),
        .res_o  (res_code)
    );

    for (genvar s = 0; s < 2; s++) begin : g_seg
        localparam int LO = (s == 0) ? 0 : LO_BITS;
        localparam int HI = (s == 0) ? LO_BITS - 1 : NBITS - 1;
        logic en_n;
        assign en_n = (s == 0) ? oe_lo_n : oe_hi_n;
        assign data_o[HI:LO] = en_n ? 'z : res_code[HI:LO];
    end
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int NBITS = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             track,
    input logic             ready,
    input logic [NBITS-1:0] trial,
    input logic [NBITS-1:0] res
);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    a_r2_trial_idle_in_track: assert property (@(posedge clk) disable iff (rst)
        track |-> (trial == '0));

    a_r6_ready_only_in_track: assert property (@(posedge clk) disable iff (rst)
        ready |-> track);

    a_r3_msb_trial_first: assert property (@(posedge clk) disable iff (rst)
        $fell(track) |-> (trial == MSB_ONLY));

    a_r4_trial_active_outside_track: assert property (@(posedge clk) disable iff (rst)
        !track |-> (trial != '0));

    a_r9_result_changes_with_ready: assert property (@(posedge clk) disable iff (rst)
        !$stable(res) |-> $rose(ready));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .track (track_o),
    .ready (ready_o),
    .trial (trial_o),
    .res   (res_code)
);

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b0;
    logic        oe_hi_n = 1'b0;
    logic        oe_lo_n = 1'b0;
    logic        track, ready;
    logic [11:0] trial;
    wire  [11:0] data;
    logic [11:0] vin = '0;
    logic        cmp;
    int          n_run = 0;
    int          n_fail = 0;
    logic [11:0] prev_code = '0;

    always #4 clk = ~clk;

    for (genvar i = 0; i < 12; i++) begin : g_pu
        pullup (data[i]);
    end

    assign cmp = (vin >= trial);

    sar_conv_seq u0 (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .cmp_i   (cmp),
        .oe_hi_n (oe_hi_n),
        .oe_lo_n (oe_lo_n),
        .track_o (track),
        .trial_o (trial),
        .ready_o (ready),
        .data_o  (data)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready_rise();
        bit seen = 0;
        for (int k = 0; k < 60 && !seen; k++) begin
            logic was = ready;
            step();
            if (!was && ready) seen = 1;
        end
        check("R1 ready rise reached", 12'(seen), 12'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(2);
        check("R11 track after reset", 12'(track), 12'd1);
        check("R11 ready after reset", 12'(ready), 12'd0);
        check("R11 trial after reset", trial, 12'h000);
        check("R11 result after reset", data, 12'h000);
        prev_code = '0;
        rst = 1'b0;
    endtask

    task automatic t_convert(input logic [11:0] code);
        vin = code;
        check("R6 ready in period 1", 12'(ready), 12'd1);
        step();
        check("R6 ready low in period 2", 12'(ready), 12'd0);
        check("R2 track in period 2", 12'(track), 12'd1);
        step();
        check("R2 track in period 3", 12'(track), 12'd1);
        check("R2 trial zero in track", trial, 12'h000);
        step();
        check("R2 track low in period 4", 12'(track), 12'd0);
        check("R3 period-4 trial", trial, 12'h800);
        step();
        check("R4 period-5 trial", trial, (code & 12'h800) | 12'h400);
        step(5);
        check("R9 result held mid-frame", data, prev_code);
        step(6);
        check("R1 ready after 15 periods", 12'(ready), 12'd1);
        check("R5 result code", data, code);
        prev_code = code;
    endtask

    task automatic t_freerun();
        start_n = 1'b0;
        wait_ready_rise();
        prev_code = data;
        t_convert(12'h000);
        t_convert(12'hFFF);
        t_convert(12'h800);
        t_convert(12'h7FF);
        t_convert(12'hA5A);
        t_convert(12'h001);
    endtask

    task automatic t_enables();
        oe_hi_n = 1'b1; oe_lo_n = 1'b0;
        #1;
        check("R10 hi part floats", data, {8'hFF, prev_code[3:0]});
        oe_hi_n = 1'b0; oe_lo_n = 1'b1;
        #1;
        check("R10 lo part floats", data, {prev_code[11:4], 4'hF});
        oe_hi_n = 1'b1; oe_lo_n = 1'b1;
        #1;
        check("R10 both float", data, 12'hFFF);
        oe_hi_n = 1'b0; oe_lo_n = 1'b0;
        #1;
        check("R10 both driven", data, prev_code);
    endtask

    task automatic t_single();
        start_n = 1'b1;
        step(20);
        check("R7 parked ready held", 12'(ready), 12'd1);
        check("R7 parked track", 12'(track), 12'd1);
        step(5);
        check("R7 still parked", 12'(ready), 12'd1);
        check("R7 parked trial zero", trial, 12'h000);
        vin = 12'h3C3;
        start_n = 1'b0;
        step(2);
        check("R8 sync latency, ready still high", 12'(ready), 12'd1);
        step();
        check("R8 ready falls on third edge", 12'(ready), 12'd0);
        check("R8 resume in track period 3", 12'(track), 12'd1);
        start_n = 1'b1;
        step();
        check("R8 trial after resume", trial, 12'h800);
        step(11);
        check("R8 ready low before 13th cycle", 12'(ready), 12'd0);
        step();
        check("R8 ready 13 cycles after fall", 12'(ready), 12'd1);
        check("R5 single-shot result", data, 12'h3C3);
        step(20);
        check("R7 parks again", 12'(ready), 12'd1);
        check("R9 result held while parked", data, 12'h3C3);
    endtask

    initial begin
        step(2);
        t_reset();
        t_freerun();
        t_enables();
        t_single();
        step(5);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R11 mid-run reset result", data, 12'h000);
        check("R11 mid-run reset ready", 12'(ready), 12'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule